// File: doc/BRIEF.md
# Overlapped Two-Stage Instruction Sequencer

This block is the control unit of a small single-address processor whose main memory needs the same fixed number of cycles for every word, whatever its address. The sequencer keeps a decode register, a sequence counter and sixteen fast working registers. It drives a one-word memory port and, for each decoded instruction, picks which stages run. Work that touches only the working registers costs nothing next to a memory access, so the memory port sets the pace of the block.

An instruction that names a memory operand runs in two stages. In stage one the operand is read or written. In stage two the following instruction is fetched, and the loaded operand is combined with its target register. An instruction that names no operand hands its stage-one access to the next-instruction fetch, so it needs only one stage. A store always writes a register value that was settled before the store began. Two counters report the cycles spent and the instructions completed, so a test can measure the cost of each instruction.

Top module: `seq_overlap_core`

## Requirements
- R1: While reset is held, the outputs show sequence counter 0, cycle count 0, retired count 0 and halted low. After reset the first access is a read of address 0, and its data becomes the first decoded instruction.
- R2: Every memory access keeps `mem_req` high with `mem_addr`, `mem_we` and `mem_wdata` unchanged for exactly LAT consecutive cycles. `mem_last` is high only in the final cycle of each access, and read data is taken in that cycle.
- R3: An instruction with no memory operand (opcodes 0, 1, 2, 6) completes in exactly LAT cycles. Its single access reads the next instruction.
- R4: An instruction with a memory operand (opcodes 3, 4, 5) completes in exactly 2*LAT cycles. The first access goes to the address field. The second access reads the instruction at sequence counter + 1.
- R5: The instruction word is 16 bits: opcode in bits [15:12], register A in bits [11:8], register B in bits [3:0], and the memory address in bits [7:0]. Opcode 1 sets A to A+B and opcode 2 sets A to B, both modulo 2^16.
- R6: Opcode 3 loads memory[addr] into A. Opcode 5 sets A to A + memory[addr]. The result is visible to the next instruction.
- R7: Opcode 4 writes the value that A held before the store began to memory[addr].
- R8: Opcode 6 fetches its successor from the address field, and the sequence counter takes that address.
- R9: Opcode 7 makes no memory access and raises `halted` one cycle after it is decoded. After that, `mem_req` stays low and both counters hold still.
- R10: The cycle count rises by one in every cycle from reset release until halted is raised. The retired count rises by one each time an instruction other than halt completes.
- R11: Opcodes 8 to 15 change no register and follow the memory-free timing of R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mem_req | output | 1 | Memory access in progress |
| mem_we | output | 1 | Access is a write |
| mem_last | output | 1 | Final cycle of the current access |
| mem_addr | output | AW | Word address of the access |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, sampled while mem_last is high |
| pc_o | output | AW | Sequence counter |
| ir_o | output | DW | Decode register |
| cycle_cnt | output | CW | Cycles since reset release, frozen at halt |
| retired_cnt | output | CW | Completed instructions |
| halted | output | 1 | Sequencer has stopped |

## Verification
The bench runs one program through every opcode and compares the port activity on every clock against a behavioural model. It also times each instruction from one retirement to the next. The test program includes a store that follows a register-only update of the same register. A design that stored a stale or a half-updated value, or that applied the update one stage too late, would leave a wrong word in memory. A jump skips over words that would overwrite a memory location and halt the machine early, so a design that fetched pc+1 instead of the jump target would corrupt that location or stop short. An undefined opcode, register-only work and a final halt are also covered. Treating unknown codes as memory operations shows up as a 2*LAT gap between retirements. Counters that keep running after halt show up as drift once the design has stopped.

// File: rtl/seq_pkg.sv
package seq_pkg;

  localparam logic [3:0] OPC_NOP   = 4'd0;
  localparam logic [3:0] OPC_ADD   = 4'd1;
  localparam logic [3:0] OPC_MOV   = 4'd2;
  localparam logic [3:0] OPC_LOAD  = 4'd3;
  localparam logic [3:0] OPC_STORE = 4'd4;
  localparam logic [3:0] OPC_ADDM  = 4'd5;
  localparam logic [3:0] OPC_JUMP  = 4'd6;
  localparam logic [3:0] OPC_HALT  = 4'd7;

  typedef enum logic [1:0] {
    PH_BOOT  = 2'd0,
    PH_OPND  = 2'd1,
    PH_FETCH = 2'd2,
    PH_HALT  = 2'd3
  } phase_e;

  typedef struct packed {
    logic mem_ref;
    logic is_store;
    logic is_jump;
    logic is_halt;
    logic wr_alu;
    logic use_add;
    logic wr_load;
    logic load_add;
  } ctrl_t;

endpackage

// File: rtl/seq_decode.sv
module seq_decode
  import seq_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 8,
  parameter int IW = 4
) (
  input  logic [DW-1:0] ir,
  output ctrl_t         ctrl,
  output logic [IW-1:0] ra,
  output logic [IW-1:0] rb,
  output logic [AW-1:0] addr
);

  localparam int OP_HI = DW - 1;
  localparam int RA_HI = DW - 5;

  logic [3:0] op;

  assign op   = ir[OP_HI -: 4];
  assign ra   = ir[RA_HI -: IW];
  assign rb   = ir[IW-1:0];
  assign addr = ir[AW-1:0];

  always_comb begin
    ctrl = '0;
    unique case (op)
      OPC_ADD:   begin ctrl.wr_alu = 1'b1; ctrl.use_add = 1'b1; end
      OPC_MOV:   ctrl.wr_alu = 1'b1;
      OPC_LOAD:  begin ctrl.mem_ref = 1'b1; ctrl.wr_load = 1'b1; end
      OPC_STORE: begin ctrl.mem_ref = 1'b1; ctrl.is_store = 1'b1; end
      OPC_ADDM:  begin ctrl.mem_ref = 1'b1; ctrl.wr_load = 1'b1; ctrl.load_add = 1'b1; end
      OPC_JUMP:  ctrl.is_jump = 1'b1;
      OPC_HALT:  ctrl.is_halt = 1'b1;
      default:   ctrl = '0;
    endcase
  end

  // R11: an unknown code never asks for an operand access or a register write
  always_comb begin
    assert_unknown_is_nop_R11: assert (!(op > OPC_HALT) || ctrl == '0);
  end

endmodule

// File: rtl/seq_access_timer.sv
module seq_access_timer #(
  parameter int LAT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic last
);

  localparam int CNTW = (LAT > 1) ? $clog2(LAT) : 1;
  localparam logic [CNTW-1:0] CNT_MAX = CNTW'(LAT - 1);

  logic [CNTW-1:0] cnt_q;
  logic [CNTW-1:0] cnt_d;
  logic            cnt_en;

  assign last   = (cnt_q == CNT_MAX);
  assign cnt_en = run;

  always_comb begin
    cnt_d = last ? '0 : cnt_q + CNTW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assert_cnt_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_MAX);

  // R2: an idle timer rests at zero so the next access gets a full LAT cycles
  assert_idle_rests_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> cnt_q == '0);

endmodule

// File: rtl/seq_regfile.sv
module seq_regfile #(
  parameter int NREG = 16,
  parameter int DW   = 16,
  localparam int IW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [IW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [IW-1:0] raddr_a,
  input  logic [IW-1:0] raddr_b,
  output logic [DW-1:0] rdata_a,
  output logic [DW-1:0] rdata_b
);

  logic [DW-1:0] regs_q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic wen;
    assign wen = we && (waddr == IW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        regs_q[g] <= '0;
      end else if (wen) begin
        regs_q[g] <= wdata;
      end
    end
  end

  assign rdata_a = regs_q[raddr_a];
  assign rdata_b = regs_q[raddr_b];

endmodule

// File: rtl/seq_overlap_core.sv
module seq_overlap_core
  import seq_pkg::*;
#(
  parameter int DW   = 16,
  parameter int AW   = 8,
  parameter int NREG = 16,
  parameter int LAT  = 4,
  parameter int CW   = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic          mem_req,
  output logic          mem_we,
  output logic          mem_last,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic [AW-1:0] pc_o,
  output logic [DW-1:0] ir_o,
  output logic [CW-1:0] cycle_cnt,
  output logic [CW-1:0] retired_cnt,
  output logic          halted
);

  localparam int IW = $clog2(NREG);

  // reset: asserted at once, released through two flops
  logic rst_s1_q;
  logic rst_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_i    <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_i    <= rst_s1_q;
    end
  end

  phase_e        state_q, state_d;
  logic [AW-1:0] pc_q, pc_d;
  logic [DW-1:0] ir_q;
  logic [DW-1:0] opnd_q;
  logic [CW-1:0] cyc_q;
  logic [CW-1:0] ret_q;
  logic          pc_en, ir_en, opnd_en, commit;

  ctrl_t         ctrl;
  logic [IW-1:0] ra, rb;
  logic [AW-1:0] addr_f;
  logic [AW-1:0] pc_inc, next_pc;

  logic          rf_we;
  logic [DW-1:0] rf_wdata;
  logic [DW-1:0] rd_a, rd_b;

  logic          run;
  logic          tlast;
  logic          acc_done;
  logic [AW-1:0] mem_addr_c;

  seq_decode #(.DW(DW), .AW(AW), .IW(IW)) u_dec (
    .ir   (ir_q),
    .ctrl (ctrl),
    .ra   (ra),
    .rb   (rb),
    .addr (addr_f)
  );

  seq_access_timer #(.LAT(LAT)) u_tmr (
    .clk   (clk),
    .rst_n (rst_i),
    .run   (run),
    .last  (tlast)
  );

  seq_regfile #(.NREG(NREG), .DW(DW)) u_rf (
    .clk     (clk),
    .rst_n   (rst_i),
    .we      (rf_we),
    .waddr   (ra),
    .wdata   (rf_wdata),
    .raddr_a (ra),
    .raddr_b (rb),
    .rdata_a (rd_a),
    .rdata_b (rd_b)
  );

  assign pc_inc   = pc_q + AW'(1);
  assign next_pc  = ctrl.is_jump ? addr_f : pc_inc;
  assign acc_done = run && tlast;

  // stage scheduling
  always_comb begin
    state_d    = state_q;
    pc_d       = pc_q;
    pc_en      = 1'b0;
    ir_en      = 1'b0;
    opnd_en    = 1'b0;
    commit     = 1'b0;
    rf_we      = 1'b0;
    rf_wdata   = rd_b;
    run        = 1'b0;
    mem_addr_c = pc_q;
    unique case (state_q)
      PH_BOOT: begin
        run        = 1'b1;
        mem_addr_c = pc_q;
        if (acc_done) begin
          ir_en   = 1'b1;
          state_d = PH_OPND;
        end
      end
      PH_OPND: begin
        if (ctrl.is_halt) begin
          state_d = PH_HALT;
        end else if (ctrl.mem_ref) begin
          run        = 1'b1;
          mem_addr_c = addr_f;
          if (acc_done) begin
            opnd_en = 1'b1;
            state_d = PH_FETCH;
          end
        end else begin
          // no operand: the next fetch takes the stage-one slot
          run        = 1'b1;
          mem_addr_c = next_pc;
          if (acc_done) begin
            ir_en    = 1'b1;
            pc_en    = 1'b1;
            pc_d     = next_pc;
            commit   = 1'b1;
            rf_we    = ctrl.wr_alu;
            rf_wdata = ctrl.use_add ? (rd_a + rd_b) : rd_b;
          end
        end
      end
      PH_FETCH: begin
        run        = 1'b1;
        mem_addr_c = pc_inc;
        if (acc_done) begin
          ir_en    = 1'b1;
          pc_en    = 1'b1;
          pc_d     = pc_inc;
          commit   = 1'b1;
          rf_we    = ctrl.wr_load;
          rf_wdata = ctrl.load_add ? (rd_a + opnd_q) : opnd_q;
          state_d  = PH_OPND;
        end
      end
      default: begin
        state_d = PH_HALT;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      state_q <= PH_BOOT;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      pc_q <= '0;
    end else if (pc_en) begin
      pc_q <= pc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      ir_q <= '0;
    end else if (ir_en) begin
      ir_q <= mem_rdata;
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      opnd_q <= '0;
    end else if (opnd_en) begin
      opnd_q <= mem_rdata;
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      cyc_q <= '0;
    end else if (state_q != PH_HALT) begin
      cyc_q <= cyc_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      ret_q <= '0;
    end else if (commit) begin
      ret_q <= ret_q + CW'(1);
    end
  end

  assign mem_req     = run;
  assign mem_last    = acc_done;
  assign mem_addr    = mem_addr_c;
  assign mem_we      = (state_q == PH_OPND) && ctrl.is_store;
  assign mem_wdata   = rd_a;
  assign pc_o        = pc_q;
  assign ir_o        = ir_q;
  assign cycle_cnt   = cyc_q;
  assign retired_cnt = ret_q;
  assign halted      = (state_q == PH_HALT);

  // R2: an access in progress keeps its address and direction
  assert_access_stable_R2: assert property (@(posedge clk) disable iff (!rst_i)
    (mem_req && !mem_last) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  // R7: store data does not move while the store is in flight
  assert_store_data_held_R7: assert property (@(posedge clk) disable iff (!rst_i)
    (mem_req && mem_we && !mem_last) |=> $stable(mem_wdata));

  // R4: an operand access is followed by a fetch of the next sequential word
  assert_fetch_follows_opnd_R4: assert property (@(posedge clk) disable iff (!rst_i)
    (state_q == PH_OPND && ctrl.mem_ref && mem_last) |=>
      (mem_req && !mem_we && mem_addr == pc_q + AW'(1)));

  // R3: retirement only at the end of an access
  assert_retire_on_last_R3: assert property (@(posedge clk) disable iff (!rst_i)
    (retired_cnt != $past(retired_cnt)) |-> $past(mem_last));

  // R10: the retired count moves by at most one per cycle
  assert_retire_step_R10: assert property (@(posedge clk) disable iff (!rst_i)
    (retired_cnt == $past(retired_cnt)) || (retired_cnt == $past(retired_cnt) + CW'(1)));

  // R9: once halted the port is quiet and the counters are frozen
  assert_halt_quiet_R9: assert property (@(posedge clk) disable iff (!rst_i)
    halted |=> (halted && !mem_req && $stable(cycle_cnt) && $stable(retired_cnt)));

endmodule

// File: tb/sim_seq_overlap_core.sv
module sim_seq_overlap_core;

  localparam int DW  = 16;
  localparam int AW  = 8;
  localparam int LAT = 4;
  localparam int CW  = 32;

  logic          clk;
  logic          rst_n;
  logic          mem_req, mem_we, mem_last;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic [DW-1:0] mem_rdata;
  logic [AW-1:0] pc_o;
  logic [DW-1:0] ir_o;
  logic [CW-1:0] cycle_cnt, retired_cnt;
  logic          halted;

  int n_checks = 0;
  int n_fail   = 0;

  seq_overlap_core #(.DW(DW), .AW(AW), .NREG(16), .LAT(LAT), .CW(CW)) u0 (
    .clk(clk), .rst_n(rst_n),
    .mem_req(mem_req), .mem_we(mem_we), .mem_last(mem_last),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .pc_o(pc_o), .ir_o(ir_o), .cycle_cnt(cycle_cnt), .retired_cnt(retired_cnt),
    .halted(halted)
  );

  // 125 MHz
  initial clk = 1'b0;
  always #4 clk = ~clk;

  // memory seen by the design
  logic [DW-1:0] mem [256];
  assign mem_rdata = mem[mem_addr];
  always @(posedge clk) begin
    if (mem_req && mem_we && mem_last) mem[mem_addr] <= mem_wdata;
  end

  // behavioural model state
  int rm [256];
  int rr [16];
  int m_pc, m_ir, m_opnd, m_phase, m_tick, m_cyc, m_ret, m_rel;
  bit started = 0;

  function automatic int op_of(int w); return (w >> 12) & 15; endfunction
  function automatic int ra_of(int w); return (w >> 8) & 15; endfunction
  function automatic int rb_of(int w); return w & 15; endfunction
  function automatic int ad_of(int w); return w & 255; endfunction
  function automatic bit is_mref(int o); return (o == 3) || (o == 4) || (o == 5); endfunction

  task automatic put(input int a, input int w);
    mem[a] = w[15:0];
    rm[a]  = w & 16'hFFFF;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_rel = 0; m_pc = 0; m_ir = 0; m_opnd = 0; m_phase = 0; m_tick = 0;
      m_cyc = 0; m_ret = 0;
      foreach (rr[i]) rr[i] = 0;
      started = 1;
    end else if (m_rel < 2) begin
      m_rel++;
    end else begin
      int o;
      o = op_of(m_ir);
      if (m_phase != 3) m_cyc++;
      case (m_phase)
        0: begin
          m_tick++;
          if (m_tick == LAT) begin m_ir = rm[m_pc]; m_tick = 0; m_phase = 1; end
        end
        1: begin
          if (o == 7) m_phase = 3;
          else if (is_mref(o)) begin
            if (o == 4 && m_tick == LAT-1) rm[ad_of(m_ir)] = rr[ra_of(m_ir)];
            m_tick++;
            if (m_tick == LAT) begin
              m_opnd = rm[ad_of(m_ir)]; m_tick = 0; m_phase = 2;
            end
          end else begin
            m_tick++;
            if (m_tick == LAT) begin
              int nx;
              if (o == 1) rr[ra_of(m_ir)] = (rr[ra_of(m_ir)] + rr[rb_of(m_ir)]) & 16'hFFFF;
              if (o == 2) rr[ra_of(m_ir)] = rr[rb_of(m_ir)];
              nx = (o == 6) ? ad_of(m_ir) : ((m_pc + 1) & 255);
              m_pc = nx; m_ir = rm[nx]; m_ret++; m_tick = 0;
            end
          end
        end
        2: begin
          m_tick++;
          if (m_tick == LAT) begin
            if (o == 3) rr[ra_of(m_ir)] = m_opnd;
            if (o == 5) rr[ra_of(m_ir)] = (rr[ra_of(m_ir)] + m_opnd) & 16'hFFFF;
            m_pc = (m_pc + 1) & 255; m_ir = rm[m_pc]; m_ret++; m_tick = 0; m_phase = 1;
          end
        end
        default: ;
      endcase
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // cycle-by-cycle comparison
  int last_ret_cyc = LAT;
  int prev_ret = 0;
  int prev_ir  = 0;
  always @(negedge clk) begin
    if (started && rst_n && m_rel >= 2) begin
      int o, e_addr;
      bit e_req, e_we;
      o = op_of(m_ir);
      e_req = (m_phase == 0) || (m_phase == 2) || (m_phase == 1 && o != 7);
      e_we  = (m_phase == 1) && (o == 4);
      case (m_phase)
        0: e_addr = m_pc;
        1: e_addr = is_mref(o) ? ad_of(m_ir) : ((o == 6) ? ad_of(m_ir) : ((m_pc + 1) & 255));
        2: e_addr = (m_pc + 1) & 255;
        default: e_addr = 0;
      endcase
      chk(mem_req == e_req, "R2", "mem_req", mem_req, e_req);
      chk(mem_last == (e_req && m_tick == LAT-1), "R2", "mem_last", mem_last, e_req && m_tick == LAT-1);
      if (e_req) begin
        chk(int'(mem_addr) == e_addr, (m_phase == 1 && o == 6) ? "R8" : "R4", "mem_addr", mem_addr, e_addr);
        chk(mem_we == e_we, "R7", "mem_we", mem_we, e_we);
        if (e_we) chk(int'(mem_wdata) == rr[ra_of(m_ir)], "R7", "mem_wdata", mem_wdata, rr[ra_of(m_ir)]);
      end
      chk(int'(pc_o) == m_pc, "R8", "pc", pc_o, m_pc);
      chk(int'(ir_o) == m_ir, "R5", "ir", ir_o, m_ir);
      chk(int'(cycle_cnt) == m_cyc, "R10", "cycle_cnt", cycle_cnt, m_cyc);
      chk(int'(retired_cnt) == m_ret, "R10", "retired_cnt", retired_cnt, m_ret);
      chk(halted == (m_phase == 3), "R9", "halted", halted, m_phase == 3);
      // per-instruction cost measured between retirements
      if (int'(retired_cnt) != prev_ret) begin
        int po, d, ed;
        po = op_of(prev_ir);
        d  = int'(cycle_cnt) - last_ret_cyc;
        ed = is_mref(po) ? 2*LAT : LAT;
        chk(d == ed, is_mref(po) ? "R4" : ((po > 7) ? "R11" : "R3"), "instruction cycles", d, ed);
        last_ret_cyc = int'(cycle_cnt);
        prev_ret = int'(retired_cnt);
      end
      prev_ir = int'(ir_o);
    end
  end

  int wd = 0;
  bit wd_hit = 0;

  initial begin
    for (int i = 0; i < 256; i++) put(i, 0);
    put(8'h40, 5);
    put(8'h41, 7);
    put(8'h53, 16'hDEAD);
    put(0,  16'h3140); // load  r1,[40]
    put(1,  16'h3241); // load  r2,[41]
    put(2,  16'h1102); // add   r1,r2  -> 12
    put(3,  16'h4150); // store r1,[50]
    put(4,  16'h2301); // mov   r3,r1
    put(5,  16'h5340); // addm  r3,[40] -> 17
    put(6,  16'h4351); // store r3,[51]
    put(7,  16'h3450); // load  r4,[50]
    put(8,  16'h4452); // store r4,[52]
    put(9,  16'h600C); // jump  0C
    put(10, 16'h4153); // skipped store
    put(11, 16'h7000); // skipped halt
    put(12, 16'hF000); // undefined code
    put(13, 16'h1404); // add   r4,r4 -> 24
    put(14, 16'h4454); // store r4,[54]
    put(15, 16'h7000); // halt

    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk(pc_o == 0, "R1", "pc in reset", pc_o, 0);
    chk(cycle_cnt == 0, "R1", "cycle_cnt in reset", cycle_cnt, 0);
    chk(retired_cnt == 0, "R1", "retired_cnt in reset", retired_cnt, 0);
    chk(halted == 0, "R1", "halted in reset", halted, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(mem_req && !mem_we && mem_addr == 0, "R1", "first access", {mem_req, mem_we, mem_addr}, {1'b1, 1'b0, 8'h00});

    while (!halted && wd < 2000) begin
      @(negedge clk);
      wd++;
    end
    if (wd >= 2000) begin
      wd_hit = 1;
      chk(1'b0, "R9", "watchdog expired", wd, 2000);
    end

    repeat (10) @(negedge clk);
    chk(mem[8'h50] == 12, "R7", "store after add", mem[8'h50], 12);
    chk(mem[8'h51] == 17, "R6", "addm result", mem[8'h51], 17);
    chk(mem[8'h52] == 12, "R6", "load of stored word", mem[8'h52], 12);
    chk(mem[8'h53] == 16'hDEAD, "R8", "jumped-over store", mem[8'h53], 16'hDEAD);
    chk(mem[8'h54] == 24, "R5", "add after undefined", mem[8'h54], 24);
    chk(mem[8'h40] == 5, "R11", "operand untouched", mem[8'h40], 5);
    chk(retired_cnt == 13, "R10", "final retired", retired_cnt, 13);
    chk(cycle_cnt == 22*LAT + 1, "R10", "final cycles", cycle_cnt, 22*LAT + 1);
    chk(!mem_req && halted, "R9", "quiet after halt", mem_req, 0);
    chk(pc_o == 15, "R9", "pc at halt", pc_o, 15);

    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule